// File: doc/BRIEF.md
# Multi-format stereo audio deserializer

This block turns a serial stereo audio stream into parallel samples. It takes three lines: a bit clock, a word clock (used as a frame sync in one format) and one data line. It delivers one 24-bit sample per word, tagged left or right. The format is picked at run time from four framing conventions, which differ in word-clock polarity, in the delay from the word-clock edge to the first data bit, and in justification. The word length is picked at run time as 16, 20 or 24 bits. Data arrives MSB first in two's complement. Each sample is placed left-aligned in the 24-bit output field, so the sign stays in bit 23 and the unused low bits read zero. Three instances serve three stereo pairs.

The serial lines are treated as asynchronous. Each one passes through a synchronizer in the system clock domain, and the bit-clock edges are detected there. Every high and low phase of the bit clock must therefore last at least two system clock cycles.

Finished words leave on a valid/ready port.
- `out_valid` rises one cycle after a word completes.
- It stays high, with data and tag held, until `out_ready` is seen high at a clock edge.
- The audio stream cannot be paused. If a new word completes while an older one is still waiting, the new word replaces the old one, and the old one is lost.

Software must apply reset after changing the format or the word length.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is high, and in the cycle after it, `out_valid`, `out_data` and `out_chan` are zero. No word is delivered before the first word-clock transition that follows reset.
- R2: Format code 0 (I2S-style): the word clock is low for left and high for right. The MSB is captured on the second rising bit-clock edge after the word clock changes.
- R3: Format code 1 (left-justified): the word clock is high for left and low for right. The MSB is captured on the first rising bit-clock edge after the word clock changes.
- R4: Format code 2 (right-justified): the word clock is high for left and low for right. The sample is the last N bits captured on rising edges before the word clock changes. It is delivered at that change and tagged with the channel of the half-frame that just ended.
- R5: Format code 3 (DSP frame sync): data and sync are captured on falling bit-clock edges. A sync seen high after being seen low marks a word start, and the MSB follows on the next falling edge.
- R6: In format code 3, words are tagged alternately, starting with left (`out_chan` = 0) after reset.
- R7: Word-length code 0 selects 24 bits, code 1 selects 20 bits, code 2 selects 16 bits, and code 3 also selects 24 bits. The sample sits in `out_data[23:24-N]` and the bits below it are zero.
- R8: Bits on the data line outside the N-bit slot of a half-frame do not change the delivered sample.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_chan` hold unless a newer word completes.
- R10: Each half-frame yields exactly one word. With `out_ready` high, `out_valid` is high for one cycle per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt | input | 2 | Framing: 0 I2S-style, 1 left-justified, 2 right-justified, 3 DSP sync |
| wlen | input | 2 | Word length: 0 = 24, 1 = 20, 2 = 16, 3 = 24 bits |
| bclk | input | 1 | Serial bit clock (asynchronous) |
| wclk | input | 1 | Word clock or frame sync (asynchronous) |
| sdata | input | 1 | Serial data, MSB first |
| out_valid | output | 1 | A sample is waiting |
| out_ready | input | 1 | The consumer accepts the sample at this edge |
| out_data | output | 24 | Sample, left-aligned two's complement |
| out_chan | output | 1 | Channel tag: 0 left, 1 right |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and a 6-bit saturating position counter. With these, each bit-clock phase can be four system cycles long and each half-frame 32 bit clocks, as at 64 bit clocks per sample. That leaves room for padding bits both before and after every word length in every format, and for a bit-clock edge count that runs past the word slot without wrapping. Back-pressure is applied on a fixed pattern throughout, with one long hold inside a half-frame. The reserved word-length code is also driven.

// File: rtl/ads_pkg.sv
package ads_pkg;

  localparam int SAMPLE_W = 24;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  // Word length in bits for a 2-bit length code; the spare code maps to 24.
  function automatic logic [4:0] word_len(input logic [1:0] code);
    case (code)
      2'd1:    word_len = 5'd20;
      2'd2:    word_len = 5'd16;
      default: word_len = 5'd24;
    endcase
  endfunction

endpackage

// File: rtl/ads_line_sync.sv
module ads_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic wclk_in,
  input  logic data_in,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic ws,
  output logic sd
);
  localparam int LINES = 3;

  logic [LINES-1:0] stage_q [STAGES];
  logic             bclk_last;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= {data_in, wclk_in, bclk_in};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) bclk_last <= 1'b0;
    else     bclk_last <= stage_q[STAGES-1][0];
  end

  assign bclk_rise = stage_q[STAGES-1][0] & ~bclk_last;
  assign bclk_fall = ~stage_q[STAGES-1][0] & bclk_last;
  assign ws        = stage_q[STAGES-1][1];
  assign sd        = stage_q[STAGES-1][2];

endmodule

// File: rtl/ads_framer.sv
module ads_framer
  import ads_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  fmt_e       fmt,
  input  logic [1:0] wlen,
  input  logic       cap,
  input  logic       ws,
  output logic       take,
  output logic       use_hist,
  output logic       word_done,
  output logic       done_chan
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             armed_q, wprev_q, active_q, chan_q, dsp_next_q;
  logic [POS_W-1:0] pos_q;

  logic             is_rj, is_dsp, edge_seen, start, act_now;
  logic             new_chan, chan_now, in_slot;
  logic [POS_W-1:0] pos_now, wl_p, off_p, end_p;

  always_comb begin
    is_rj     = (fmt == FMT_RJ);
    is_dsp    = (fmt == FMT_DSP);
    edge_seen = is_dsp ? (ws & ~wprev_q) : (ws ^ wprev_q);
    start     = cap & armed_q & edge_seen;
    if (start)                pos_now = '0;
    else if (pos_q == POS_MAX) pos_now = pos_q;
    else                      pos_now = pos_q + 1'b1;
    act_now   = active_q | start;
    wl_p      = POS_W'(word_len(wlen));
    off_p     = (fmt == FMT_LJ) ? '0 : POS_W'(1);
    end_p     = off_p + wl_p;
    in_slot   = act_now && (pos_now >= off_p) && (pos_now < end_p);
    case (fmt)
      FMT_I2S: new_chan = ws;
      FMT_DSP: new_chan = dsp_next_q;
      default: new_chan = ~ws;
    endcase
    chan_now  = start ? new_chan : chan_q;
    take      = cap & (is_rj | in_slot);
    use_hist  = is_rj;
    if (is_rj) word_done = start & active_q;
    else       word_done = cap & act_now & (pos_now == end_p - 1'b1);
    done_chan = is_rj ? chan_q : chan_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q    <= 1'b0;
      wprev_q    <= 1'b0;
      active_q   <= 1'b0;
      chan_q     <= 1'b0;
      dsp_next_q <= 1'b0;
      pos_q      <= '0;
    end else if (cap) begin
      armed_q  <= 1'b1;
      wprev_q  <= ws;
      pos_q    <= pos_now;
      active_q <= act_now;
      if (start) chan_q <= new_chan;
      if (start && is_dsp) dsp_next_q <= ~dsp_next_q;
    end
  end

endmodule

// File: rtl/ads_assembler.sv
module ads_assembler
  import ads_pkg::*;
#(
  parameter int WIDTH = SAMPLE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             sd,
  input  logic             use_hist,
  input  logic [1:0]       wlen,
  output logic [WIDTH-1:0] aligned
);
  localparam int AMT_W = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] hist_q, hist_n, src;
  logic [AMT_W-1:0] amt;

  always_comb begin
    hist_n  = {hist_q[WIDTH-2:0], sd};
    src     = use_hist ? hist_q : hist_n;
    amt     = AMT_W'(WIDTH) - AMT_W'(word_len(wlen));
    aligned = src << amt;
  end

  always_ff @(posedge clk) begin
    if (rst)       hist_q <= '0;
    else if (take) hist_q <= hist_n;
  end

endmodule

// File: rtl/ads_out_stage.sv
module ads_out_stage #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             load_chan,
  input  logic             ready,
  output logic             valid,
  output logic [WIDTH-1:0] data,
  output logic             chan
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
      chan  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
      chan  <= load_chan;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import ads_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          fmt,
  input  logic [1:0]          wlen,
  input  logic                bclk,
  input  logic                wclk,
  input  logic                sdata,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_chan
);
  fmt_e                fmt_sel;
  logic                b_rise, b_fall, ws_s, sd_s, cap;
  logic                take, use_hist, word_done, word_chan;
  logic [SAMPLE_W-1:0] word_aligned;

  assign fmt_sel = fmt_e'(fmt);
  assign cap     = (fmt_sel == FMT_DSP) ? b_fall : b_rise;

  ads_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bclk_in(bclk), .wclk_in(wclk), .data_in(sdata),
    .bclk_rise(b_rise), .bclk_fall(b_fall), .ws(ws_s), .sd(sd_s)
  );

  ads_framer #(.POS_W(POS_W)) u_framer (
    .clk(clk), .rst(rst), .fmt(fmt_sel), .wlen(wlen), .cap(cap), .ws(ws_s),
    .take(take), .use_hist(use_hist), .word_done(word_done), .done_chan(word_chan)
  );

  ads_assembler #(.WIDTH(SAMPLE_W)) u_asm (
    .clk(clk), .rst(rst), .take(take), .sd(sd_s), .use_hist(use_hist),
    .wlen(wlen), .aligned(word_aligned)
  );

  ads_out_stage #(.WIDTH(SAMPLE_W)) u_out (
    .clk(clk), .rst(rst), .load(word_done), .load_data(word_aligned),
    .load_chan(word_chan), .ready(out_ready), .valid(out_valid),
    .data(out_data), .chan(out_chan)
  );

endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  fmt,
  input logic [1:0]  wlen,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_data,
  input logic        out_chan,
  input logic        word_done,
  input logic        word_chan
);
  logic dsp_expect_q;

  always_ff @(posedge clk) begin
    if (rst) dsp_expect_q <= 1'b0;
    else if (word_done && fmt == 2'd3) dsp_expect_q <= ~dsp_expect_q;
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_hold_valid_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid);

  p_hold_data_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !word_done |=> $stable(out_data) && $stable(out_chan));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !word_done |=> !out_valid);

  p_low_zero16_r7: assert property (@(posedge clk) disable iff (rst)
    word_done && wlen == 2'd2 |=> out_data[7:0] == 8'd0);

  p_low_zero20_r7: assert property (@(posedge clk) disable iff (rst)
    word_done && wlen == 2'd1 |=> out_data[3:0] == 4'd0);

  p_dsp_alt_r6: assert property (@(posedge clk) disable iff (rst)
    word_done && fmt == 2'd3 |-> word_chan == dsp_expect_q);

endmodule

bind audio_serial_rx audio_serial_rx_chk u_chk (
  .clk(clk), .rst(rst), .fmt(fmt), .wlen(wlen), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_chan(out_chan),
  .word_done(word_done), .word_chan(word_chan)
);

// File: tb/test_audio_serial_rx.sv
module test_audio_serial_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt = 2'd0;
  logic [1:0]  wlen = 2'd0;
  logic        bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic        out_valid, out_ready, out_chan;
  logic [23:0] out_data;

  int checks = 0, fails = 0, cyc = 0;
  bit hold_ready = 1'b0, finished = 1'b0;
  logic [23:0] exp_data[$];
  logic        exp_chan[$];
  string       exp_tag[$];

  always #5 clk = ~clk;

  audio_serial_rx i_audio_serial_rx (
    .clk(clk), .rst(rst), .fmt(fmt), .wlen(wlen), .bclk(bclk), .wclk(wclk),
    .sdata(sdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_chan(out_chan)
  );

  // Ready for the next edge is set first, then the handshake at that edge is modelled.
  always @(negedge clk) begin
    cyc++;
    out_ready = hold_ready ? 1'b0 : ((cyc % 3) != 2);
    if (!rst && out_valid && out_ready) begin
      checks++;
      if (exp_data.size() == 0) begin
        fails++;
        $display("FAIL R10 spurious word: data=%h chan=%0d expected none", out_data, out_chan);
      end else begin
        if (out_data !== exp_data[0] || out_chan !== exp_chan[0]) begin
          fails++;
          $display("FAIL %s: data=%h chan=%0d expected data=%h chan=%0d",
                   exp_tag[0], out_data, out_chan, exp_data[0], exp_chan[0]);
        end
        void'(exp_data.pop_front());
        void'(exp_chan.pop_front());
        void'(exp_tag.pop_front());
      end
    end
  end

  task automatic drive_bit(input logic [1:0] f, input logic w, input logic s);
    if (f == 2'd3) begin
      bclk = 1'b1; wclk = w; sdata = s;
      repeat (4) @(negedge clk);
      bclk = 1'b0;
      repeat (4) @(negedge clk);
    end else begin
      bclk = 1'b0; wclk = w; sdata = s;
      repeat (4) @(negedge clk);
      bclk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic send_half(input logic [1:0] f, input int wl, input logic [23:0] s,
                           input logic ch, input bit push, input string tag);
    logic [23:0] m;
    logic        w, b;
    m = s & ((24'd1 << wl) - 24'd1);
    if (push) begin
      exp_data.push_back(m << (24 - wl));
      exp_chan.push_back(ch);
      exp_tag.push_back(tag);
    end
    w = (f == 2'd0) ? ch : ~ch;
    for (int k = 0; k < 32; k++) begin
      b = k[0];
      case (f)
        2'd1: if (k < wl) b = m[wl-1-k];
        2'd2: if (k >= 32 - wl) b = m[31-k];
        default: if (k >= 1 && k <= wl) b = m[wl-k];
      endcase
      if (f == 2'd3) w = (k == 0);
      drive_bit(f, w, b);
    end
  endtask

  task automatic run(input logic [1:0] f, input logic [1:0] code, input int nhalf,
                     input string tag, input bit do_hold);
    int          wl;
    logic        idle_w;
    logic [23:0] smp;
    wl = (code == 2'd1) ? 20 : (code == 2'd2) ? 16 : 24;
    rst = 1'b1; fmt = f; wlen = code; bclk = 1'b0; sdata = 1'b0;
    idle_w = (f == 2'd0);
    wclk = idle_w;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 24'd0 || out_chan !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state: valid=%0d data=%h chan=%0d expected 0 000000 0",
               out_valid, out_data, out_chan);
    end
    for (int k = 0; k < 4; k++) drive_bit(f, (f == 2'd3) ? 1'b0 : idle_w, 1'b1);
    if (do_hold) begin
      fork
        begin
          logic [23:0] held_d;
          logic        held_c;
          hold_ready = 1'b1;
          wait (out_valid === 1'b1);
          @(negedge clk);
          held_d = out_data; held_c = out_chan;
          repeat (40) @(negedge clk);
          checks++;
          if (out_valid !== 1'b1 || out_data !== held_d || out_chan !== held_c) begin
            fails++;
            $display("FAIL R9 hold: valid=%0d data=%h chan=%0d expected 1 %h %0d",
                     out_valid, out_data, out_chan, held_d, held_c);
          end
          hold_ready = 1'b0;
        end
      join_none
    end
    for (int i = 0; i < nhalf; i++) begin
      smp = 24'h35A7C9 * (i + 3) + {cyc[7:0], 16'h0081};
      if (i == 0) smp = 24'h800001;
      if (i == 1) smp = 24'h7FFFFE;
      send_half(f, wl, smp, i[0], 1'b1, tag);
    end
    if (f == 2'd2) send_half(f, wl, 24'h0F0F0F, nhalf[0], 1'b0, tag);
    repeat (60) @(negedge clk);
    checks++;
    if (exp_data.size() != 0) begin
      fails++;
      $display("FAIL %s missing words: got %0d left over, expected 0", tag, exp_data.size());
      exp_data.delete(); exp_chan.delete(); exp_tag.delete();
    end
  endtask

  initial begin
    out_ready = 1'b1;
    run(2'd0, 2'd0, 6, "R2 R8 R10", 1'b0);
    run(2'd0, 2'd2, 4, "R2 R7", 1'b0);
    run(2'd1, 2'd1, 4, "R3 R7 R8", 1'b0);
    run(2'd1, 2'd0, 4, "R3 R9", 1'b1);
    run(2'd2, 2'd0, 5, "R4 R8", 1'b0);
    run(2'd2, 2'd2, 4, "R4 R7", 1'b0);
    run(2'd3, 2'd0, 5, "R5 R6", 1'b0);
    run(2'd3, 2'd3, 4, "R5 R7", 1'b0);
    run(2'd3, 2'd1, 4, "R6 R7", 1'b0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule